// File: doc/BRIEF.md
# Toggle-Write Magnetic Memory Sequencer

This block sits between a simple host request port and a magnetic memory array whose cells cannot be set to a value. A cell of this type only changes state when it receives a pulse, and each pulse inverts its current state. The block therefore turns every host write into a read-modify-toggle sequence:

1. It senses the addressed word.
2. It compares the stored word with the requested word bit by bit.
3. It raises the row pulse.
4. Inside the row window, it pulses only the columns whose bits must change.

A host read senses the word and returns it. Four small timing registers set the sense time, the row-before-column lead, the column pulse width and the row-after-column tail. Characterization can then tune the phases without changing the logic.

The host sees a single request/ready handshake. A request is taken only while `ready` is high. `ready` stays low until the whole sequence has finished. The array side has four parts:

- a word address;
- a row pulse;
- a column enable for each bit;
- a sense strobe, with the sensed word coming back on `arr_rdata`.

Top module: `tgl_mem_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `arr_row_on`, `arr_sense` and every bit of `arr_col_en` are 0, and all four timing registers hold 2.
- R2: A read (`we`=0) accepted with `req`=1 while `ready`=1 returns the word stored at `addr` on `rdata` by the time `ready` rises again, and leaves the array unchanged.
- R3: Every access, write or read, first asserts `arr_sense` on the addressed word. No row pulse is raised before the sense phase of that access.
- R4: A write pulses exactly the columns where the stored bit differs from `wdata`, once each. Afterwards the addressed word equals `wdata`, and no other bit of the array changes.
- R5: A column enable is only ever high while `arr_row_on` is high. The row pulse rises at least one cycle before the columns rise and stays high at least one cycle after they fall. Column enables stay constant while asserted.
- R6: The sense strobe lasts S cycles. The row lead before the columns lasts L cycles, the column pulse lasts W cycles and the row tail after the columns lasts H cycles. Each of S, L, W and H is taken from its timing register, and a register value of 0 acts as 1.
- R7: A write whose data equals the stored word raises no row or column pulse. `ready` is low for exactly S+2 cycles. A read holds `ready` low for S+1 cycles, and a changing write holds it low for S+2+L+W+H cycles.
- R8: Once a request is accepted, `ready` stays low until the sequence ends. Requests presented while `ready` is low are ignored and do not alter any word.
- R9: A pulse of `cfg_we` writes `cfg_wdata` into the timing register chosen by `cfg_sel`: 0 = sense (S), 1 = row lead (L), 2 = column width (W), 3 = row tail (H).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Host access request, taken when `ready` is 1 |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 13 | Word address |
| wdata | input | 22 | Write data |
| rdata | output | 22 | Data returned by the most recent read |
| ready | output | 1 | Idle and able to take a request |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_sel | input | 2 | Timing register select |
| cfg_wdata | input | 4 | Timing register value, in cycles |
| arr_addr | output | 13 | Array word address |
| arr_row_on | output | 1 | Row (word line) pulse |
| arr_col_en | output | 22 | Column toggle enables, one per bit |
| arr_sense | output | 1 | Sense strobe |
| arr_rdata | input | 22 | Sensed word from the array |

## Verification
The checker assumes that the array returns a settled word on `arr_rdata` for the whole sense window. It also assumes that timing registers are only rewritten while the block is idle, so each phase of one access uses one fixed length. The bench keeps to both assumptions. Its behavioural array updates `arr_rdata` half a cycle after any toggle, and it writes the timing registers only between completed accesses. Host requests during a busy sequence are presented on purpose, because the block must ignore them.

// File: rtl/tgl_mem_pkg.sv
`timescale 1ns/1ps
package tgl_mem_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_SETUP,
      ST_SENSE,
      ST_DECIDE,
      ST_ROW_LEAD,
      ST_COL_PULSE,
      ST_ROW_TAIL
   } seq_state_e;

   localparam int NUM_PHASES = 4;
   localparam int PH_SENSE   = 0;
   localparam int PH_SETUP   = 1;
   localparam int PH_WIDTH   = 2;
   localparam int PH_HOLD    = 3;

endpackage

// File: rtl/tgl_timing_regs.sv
`timescale 1ns/1ps
module tgl_timing_regs
   import tgl_mem_pkg::*;
#(
   parameter int CNT_W     = 4,
   parameter int RESET_CNT = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [1:0]                        wr_sel,
   input  logic [CNT_W-1:0]                  wr_val,
   output logic [NUM_PHASES-1:0][CNT_W-1:0]  len_o
);

   localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RESET_CNT);

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            len_o[p] <= RST_VAL;
         end else if (wr_en && (int'(wr_sel) == p)) begin
            len_o[p] <= wr_val;
         end
      end
   end

endmodule

// File: rtl/tgl_phase_timer.sv
`timescale 1ns/1ps
module tgl_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len_i,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] start_val;

   // A programmed length of zero behaves as a single cycle.
   assign start_val = (len_i == '0) ? '0 : len_i - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= start_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/tgl_toggle_decide.sv
`timescale 1ns/1ps
module tgl_toggle_decide #(
   parameter int DATA_W = 22
) (
   input  logic [DATA_W-1:0] stored,
   input  logic [DATA_W-1:0] wanted,
   output logic [DATA_W-1:0] flip_mask,
   output logic              any_flip
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign flip_mask[b] = stored[b] ^ wanted[b];
   end

   assign any_flip = |flip_mask;

endmodule

// File: rtl/tgl_mem_ctrl.sv
`timescale 1ns/1ps
module tgl_mem_ctrl
   import tgl_mem_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int DATA_W    = 22,
   parameter int CNT_W     = 4,
   parameter int RESET_CNT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ready,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CNT_W-1:0]  cfg_wdata,
   output logic [ADDR_W-1:0] arr_addr,
   output logic              arr_row_on,
   output logic [DATA_W-1:0] arr_col_en,
   output logic              arr_sense,
   input  logic [DATA_W-1:0] arr_rdata
);

   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr
      $error("tgl_mem_ctrl: ADDR_W out of range");
   end
   if (DATA_W < 1 || DATA_W > 128) begin : g_bad_data
      $error("tgl_mem_ctrl: DATA_W out of range");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("tgl_mem_ctrl: CNT_W out of range");
   end
   if (RESET_CNT < 0 || RESET_CNT >= (1 << CNT_W)) begin : g_bad_rst
      $error("tgl_mem_ctrl: RESET_CNT does not fit CNT_W");
   end

   seq_state_e state_q, state_d;

   logic [ADDR_W-1:0]                addr_q;
   logic [DATA_W-1:0]                wdata_q;
   logic                             we_q;
   logic [DATA_W-1:0]                old_q;
   logic [DATA_W-1:0]                mask_q;
   logic [DATA_W-1:0]                rdata_q;
   logic [NUM_PHASES-1:0][CNT_W-1:0] cfg_len;
   logic                             tmr_load;
   logic [CNT_W-1:0]                 tmr_len;
   logic                             tmr_done;
   logic [DATA_W-1:0]                flip_mask;
   logic                             any_flip;
   logic                             accept;

   tgl_timing_regs #(.CNT_W(CNT_W), .RESET_CNT(RESET_CNT)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_sel (cfg_sel),
      .wr_val (cfg_wdata),
      .len_o  (cfg_len)
   );

   tgl_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .len_i   (tmr_len),
      .expired (tmr_done)
   );

   tgl_toggle_decide #(.DATA_W(DATA_W)) u_decide (
      .stored    (old_q),
      .wanted    (wdata_q),
      .flip_mask (flip_mask),
      .any_flip  (any_flip)
   );

   assign accept = (state_q == ST_IDLE) && req;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_len  = cfg_len[PH_SENSE];
      unique case (state_q)
         ST_IDLE: begin
            if (req) state_d = ST_RD_SETUP;
         end
         ST_RD_SETUP: begin
            state_d  = ST_SENSE;
            tmr_load = 1'b1;
            tmr_len  = cfg_len[PH_SENSE];
         end
         ST_SENSE: begin
            if (tmr_done) state_d = we_q ? ST_DECIDE : ST_IDLE;
         end
         ST_DECIDE: begin
            if (any_flip) begin
               state_d  = ST_ROW_LEAD;
               tmr_load = 1'b1;
               tmr_len  = cfg_len[PH_SETUP];
            end else begin
               state_d  = ST_IDLE;
            end
         end
         ST_ROW_LEAD: begin
            if (tmr_done) begin
               state_d  = ST_COL_PULSE;
               tmr_load = 1'b1;
               tmr_len  = cfg_len[PH_WIDTH];
            end
         end
         ST_COL_PULSE: begin
            if (tmr_done) begin
               state_d  = ST_ROW_TAIL;
               tmr_load = 1'b1;
               tmr_len  = cfg_len[PH_HOLD];
            end
         end
         ST_ROW_TAIL: begin
            if (tmr_done) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         we_q    <= 1'b0;
      end else if (accept) begin
         addr_q  <= addr;
         wdata_q <= wdata;
         we_q    <= we;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         old_q   <= '0;
         rdata_q <= '0;
      end else if (state_q == ST_SENSE && tmr_done) begin
         old_q <= arr_rdata;
         if (!we_q) rdata_q <= arr_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      mask_q <= '0;
      else if (state_q == ST_DECIDE)   mask_q <= flip_mask;
   end

   assign ready      = (state_q == ST_IDLE);
   assign rdata      = rdata_q;
   assign arr_addr   = addr_q;
   assign arr_sense  = (state_q == ST_SENSE);
   assign arr_row_on = (state_q == ST_ROW_LEAD) || (state_q == ST_COL_PULSE)
                       || (state_q == ST_ROW_TAIL);
   assign arr_col_en = (state_q == ST_COL_PULSE) ? mask_q : '0;

endmodule

// File: rtl/tgl_mem_ctrl_chk.sv
`timescale 1ns/1ps
module tgl_mem_ctrl_chk #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ready,
   input logic [ADDR_W-1:0] arr_addr,
   input logic              arr_row_on,
   input logic [DATA_W-1:0] arr_col_en,
   input logic              arr_sense
);

   logic sensed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sensed_q <= 1'b0;
      else if (ready)     sensed_q <= 1'b0;
      else if (arr_sense) sensed_q <= 1'b1;
   end

   assert_col_in_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|arr_col_en) |-> arr_row_on);

   assert_row_leads_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|arr_col_en) |-> $past(arr_row_on));

   assert_row_trails_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(|arr_col_en) |-> arr_row_on);

   assert_col_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((|arr_col_en) && $past(|arr_col_en)) |-> $stable(arr_col_en));

   assert_sense_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arr_row_on) |-> sensed_q);

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!arr_row_on && !arr_sense && (arr_col_en == '0)));

   assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && $past(!ready)) |-> $stable(arr_addr));

endmodule

bind tgl_mem_ctrl tgl_mem_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ready      (ready),
   .arr_addr   (arr_addr),
   .arr_row_on (arr_row_on),
   .arr_col_en (arr_col_en),
   .arr_sense  (arr_sense)
);

// File: tb/tb_tgl_mem_ctrl.sv
`timescale 1ns/1ps
module tb_tgl_mem_ctrl;

   localparam int AW = 13;
   localparam int DW = 22;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic          we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          ready;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [CW-1:0] cfg_wdata = '0;
   logic [AW-1:0] arr_addr;
   logic          arr_row_on;
   logic [DW-1:0] arr_col_en;
   logic          arr_sense;
   logic [DW-1:0] arr_rdata = '0;

   always #5 clk = ~clk;

   tgl_mem_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ready(ready), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .arr_addr(arr_addr),
      .arr_row_on(arr_row_on), .arr_col_en(arr_col_en),
      .arr_sense(arr_sense), .arr_rdata(arr_rdata)
   );

   int total = 0;
   int bad   = 0;
   bit done_flag = 1'b0;

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural toggle array and the bench's own expected contents
   logic [DW-1:0] model_mem  [int];
   logic [DW-1:0] shadow_mem [int];
   int            flips_total = 0;
   logic [DW-1:0] col_prev = '0;

   function automatic logic [DW-1:0] init_word(int a);
      return DW'((a * 32'h9E37) ^ 32'h15A5A5);
   endfunction
   function automatic logic [DW-1:0] model_get(int a);
      return model_mem.exists(a) ? model_mem[a] : init_word(a);
   endfunction
   function automatic logic [DW-1:0] shadow_get(int a);
      return shadow_mem.exists(a) ? shadow_mem[a] : init_word(a);
   endfunction

   always @(negedge clk) begin
      logic [DW-1:0] w;
      w = model_get(int'(arr_addr));
      for (int i = 0; i < DW; i++) begin
         if (arr_row_on && arr_col_en[i] && !col_prev[i]) begin
            w[i] = ~w[i];
            flips_total++;
         end
      end
      model_mem[int'(arr_addr)] = w;
      col_prev  = arr_col_en;
      arr_rdata = w;
   end

   // timing register mirror: sense, lead, width, tail
   int cfg_m [4] = '{2, 2, 2, 2};
   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   typedef struct {
      bit            is_rd;
      int            a;
      logic [DW-1:0] exp_word;
      int            lat;
      int            rowc;
      int            colc;
      int            sensec;
      int            flips;
   } item_t;
   item_t sb [$];

   // monitor
   bit prev_ready = 1'b1;
   int lat_c = 0, row_c = 0, col_c = 0, sen_c = 0, flip_start = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if ((|arr_col_en) && !arr_row_on)
            check(1'b0, "R5 column without row", 32'(arr_col_en), 32'h0);
         if (!ready) begin
            lat_c++;
            if (arr_row_on) row_c++;
            if (|arr_col_en) col_c++;
            if (arr_sense) sen_c++;
         end
         if (ready && !prev_ready) begin
            if (sb.size() == 0) begin
               check(1'b0, "R8 completion without request", 32'h1, 32'h0);
            end else begin
               item_t it;
               it = sb.pop_front();
               check(lat_c == it.lat, it.is_rd ? "R7 read busy cycles" : "R7 write busy cycles",
                     32'(lat_c), 32'(it.lat));
               check(sen_c == it.sensec, "R6 sense cycles", 32'(sen_c), 32'(it.sensec));
               check(row_c == it.rowc, "R6 row pulse cycles", 32'(row_c), 32'(it.rowc));
               check(col_c == it.colc, "R6 column pulse cycles", 32'(col_c), 32'(it.colc));
               check(flips_total - flip_start == it.flips, "R4 toggled bit count",
                     32'(flips_total - flip_start), 32'(it.flips));
               if (it.is_rd)
                  check(rdata == it.exp_word, "R2 read data", 32'(rdata), 32'(it.exp_word));
               else
                  check(model_get(it.a) == it.exp_word, "R4 array word after write",
                        32'(model_get(it.a)), 32'(it.exp_word));
            end
            lat_c = 0; row_c = 0; col_c = 0; sen_c = 0;
            flip_start = flips_total;
         end
      end
      prev_ready = ready;
   end

   // driver
   task automatic do_op(bit is_wr, int a, logic [DW-1:0] d, bit poke = 1'b0, int poke_a = 0);
      item_t it;
      logic [DW-1:0] old, diff;
      int s, l, w, h;
      old  = shadow_get(a);
      diff = is_wr ? (old ^ d) : '0;
      s = eff(cfg_m[0]); l = eff(cfg_m[1]); w = eff(cfg_m[2]); h = eff(cfg_m[3]);
      it.is_rd  = !is_wr;
      it.a      = a;
      it.exp_word = is_wr ? d : old;
      it.sensec = s;
      if (!is_wr)          it.lat = s + 1;
      else if (diff == '0) it.lat = s + 2;
      else                 it.lat = s + 2 + l + w + h;
      it.rowc  = (diff != '0) ? (l + w + h) : 0;
      it.colc  = (diff != '0) ? w : 0;
      it.flips = $countones(diff);
      sb.push_back(it);
      if (is_wr) shadow_mem[a] = d;
      while (!ready) @(negedge clk);
      req = 1'b1; we = is_wr; addr = AW'(a); wdata = d;
      @(negedge clk);
      req = 1'b0;
      if (poke) begin
         req = 1'b1; we = 1'b1; addr = AW'(poke_a); wdata = ~init_word(poke_a);
         @(negedge clk);
         @(negedge clk);
         req = 1'b0;
      end
      while (!ready) @(negedge clk);
   endtask

   task automatic cfg_write(int sel, int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = CW'(val);
      @(negedge clk);
      cfg_we = 1'b0;
      cfg_m[sel] = val;
   endtask

   task automatic summary();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R8 actual=hung expected=complete");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(ready == 1'b1, "R1 ready after reset", 32'(ready), 32'h1);
      check(arr_row_on == 1'b0, "R1 row idle", 32'(arr_row_on), 32'h0);
      check(arr_col_en == '0, "R1 columns idle", 32'(arr_col_en), 32'h0);
      check(arr_sense == 1'b0, "R1 sense idle", 32'(arr_sense), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 defaults of 2 are visible in the first latencies (R2, R3)
      do_op(1'b0, 5, '0);
      do_op(1'b0, 6, '0);
      do_op(1'b1, 5, 22'h2AAAAA);                 // R4 changing write
      do_op(1'b0, 5, '0);                         // R2 read-back
      do_op(1'b1, 5, 22'h2AAAAA);                 // R7 same data, no pulse
      do_op(1'b0, 6, '0);                         // R4 neighbour untouched
      do_op(1'b1, 8191, 22'h3FFFFF);
      do_op(1'b0, 8191, '0);
      do_op(1'b1, 0, 22'h000000);
      do_op(1'b0, 0, '0);

      // R9 register select encoding, R6 zero acts as one
      cfg_write(0, 3);
      cfg_write(1, 1);
      cfg_write(2, 4);
      cfg_write(3, 0);
      do_op(1'b1, 100, 22'h155555);
      do_op(1'b0, 100, '0);
      do_op(1'b1, 100, 22'h155554);               // single bit flip
      do_op(1'b0, 100, '0);

      // R8 request while busy is ignored
      do_op(1'b1, 200, ~init_word(200), 1'b1, 300);
      do_op(1'b0, 300, '0);
      do_op(1'b0, 200, '0);

      cfg_write(0, 1);
      cfg_write(2, 7);
      cfg_write(3, 5);
      for (int k = 0; k < 6; k++) begin
         do_op(1'b1, 1000 + k, DW'(32'h0F0F0F * (k + 1)));
         do_op(1'b0, 1000 + k, '0);
      end
      do_op(1'b0, 999, '0);

      repeat (4) @(negedge clk);
      check(sb.size() == 0, "R8 all requests completed", 32'(sb.size()), 32'h0);
      summary();
   end

endmodule